// File: doc/BRIEF.md
# UART Register Front End with Busy-Guarded Line Control

This block is the software-visible register front end of a 16550-style UART that sits on a memory-mapped bus. It decodes the bus address into register selects, keeps the line-control, interrupt-enable and divisor registers, and passes transmit bytes, receive pops and FIFO flush strobes to a separate serial engine. The engine owns the shifters, the baud generator and the 16-entry FIFOs. It reports back its busy state, both FIFO fill levels and the byte at the head of the receive FIFO.

The line-control register is protected. A write to it while the serial engine reports busy is dropped, so the divisor-latch access bit cannot flip in the middle of a frame. The dropped write latches a busy-detect interrupt. Only a read of the status register at word offset 0x1F clears that interrupt. Each register offset is multiplied by 2^REG_SHIFT to form its byte address, so the block can sit on byte-, half- or word-spaced buses.

Top module: `uart_regblk`

## Requirements
- R1: After reset, the line-control value, the interrupt enables, the divisor, the FIFO enable and every strobe are zero, `irq` is low, and an IIR read returns 0x01.
- R2: While line-control bit 7 (divisor access) is 1, word offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The `divisor` output is {high, low}, and offset 0 writes cause no transmit push.
- R3: While line-control bit 7 is 0, a write to offset 0 pulses `tx_push` for one cycle with `tx_byte` equal to the written byte. A read of offset 0 returns `rx_head` and pulses `rx_pop` when the receive level is non-zero. Offset 1 is the interrupt-enable register: bit 0 enables receive-data, bit 1 enables transmit-empty, and only bits 3:0 are kept (upper bits read 0).
- R4: A write to line control (offset 3) while `eng_busy` is high leaves the line-control value unchanged, including bit 7. The same write with `eng_busy` low stores the byte.
- R5: A dropped line-control write sets a busy-detect pending flag. That flag makes IIR bits 3:0 read 0x7 when no higher source is active and drives `irq` high. IIR reads leave it set. A read of the status register clears it.
- R6: The status register at offset 0x1F reads {3'b0, rx full, rx not empty, tx empty, tx not full, busy}. With everything idle it reads 0x06.
- R7: A write to offset 2 (FCR) stores bit 0 as the FIFO enable and turns bit 1 into a one-cycle `rx_flush` pulse and bit 2 into a one-cycle `tx_flush` pulse. IIR bits 7:6 read 2'b11 while the FIFO enable is set.
- R8: IIR bits 3:0 report the highest pending source: receive data (rx level non-zero and enabled) 0x4, then transmit empty (tx level zero and enabled) 0x2, then busy-detect 0x7, else 0x1. `irq` is high exactly when the code is not 0x1.
- R9: The register at word offset k sits at byte address k << REG_SHIFT. An address with any of its low REG_SHIFT bits set selects nothing: it reads 0 and its write is ignored.
- R10: A data write while the transmit level equals FIFO_DEPTH produces no `tx_push`. A data read with receive level zero produces no `rx_pop`.
- R11: Every read returns its data on `rd_data` with `rd_valid` high in the cycle after the request. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| eng_busy | input | 1 | Serial engine busy (shifting, tx FIFO non-empty, or mid-frame receive) |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_head | input | 8 | Byte at the head of the receive FIFO |
| tx_push | output | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | output | 8 | Byte to transmit |
| rx_pop | output | 1 | Pop the receive FIFO |
| tx_flush | output | 1 | One-cycle transmit FIFO clear |
| rx_flush | output | 1 | One-cycle receive FIFO clear |
| fifo_on | output | 1 | FIFO enable from FCR |
| line_ctrl | output | 8 | Current line-control value |
| divisor | output | 16 | Baud divisor {high, low} |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with REG_SHIFT=2, ADDR_W=8 and FIFO_DEPTH=16. With REG_SHIFT=2 the status register lands at byte 0x7C, and an address with a low bit set, such as 0x0D, can check that misaligned accesses select nothing. FIFO_DEPTH=16 lets the bench drive a transmit level at exactly full, which covers the dropped push and the cleared tx-not-full status bit, and a receive level at exactly full, which sets the rx-full bit.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RXTX,
        SEL_IER,
        SEL_DLL,
        SEL_DLH,
        SEL_IIRFCR,
        SEL_LCR,
        SEL_STAT
    } reg_sel_e;

    // Word offsets (scaled by REG_SHIFT on the bus)
    localparam int OFF_DATA   = 0;
    localparam int OFF_IER    = 1;
    localparam int OFF_IIRFCR = 2;
    localparam int OFF_LCR    = 3;
    localparam int OFF_STAT   = 31;

    // Interrupt identification codes, highest priority first
    localparam logic [3:0] IID_RXAV = 4'h4;
    localparam logic [3:0] IID_THRE = 4'h2;
    localparam logic [3:0] IID_BUSY = 4'h7;
    localparam logic [3:0] IID_NONE = 4'h1;

    typedef struct packed {
        logic [7:0] lcr;
        logic [3:0] ier;
        logic [7:0] dll;
        logic [7:0] dlh;
        logic       fifo_on;
        logic       busy_pend;
        logic       tx_push;
        logic [7:0] tx_byte;
        logic       rx_pop;
        logic       tx_flush;
        logic       rx_flush;
        logic [7:0] rd_data;
        logic       rd_valid;
    } regs_t;

endpackage

// File: rtl/uart_regblk_decode.sv
module uart_regblk_decode
    import uart_regblk_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int REG_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dlab,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << REG_SHIFT) - 1);

    logic [ADDR_W-1:0] off;
    logic              misaligned;

    always_comb begin
        misaligned = |(addr & LOW_MASK);
        off        = addr >> REG_SHIFT;
        sel        = SEL_NONE;
        if (!misaligned) begin
            if (off == ADDR_W'(OFF_DATA))        sel = dlab ? SEL_DLL : SEL_RXTX;
            else if (off == ADDR_W'(OFF_IER))    sel = dlab ? SEL_DLH : SEL_IER;
            else if (off == ADDR_W'(OFF_IIRFCR)) sel = SEL_IIRFCR;
            else if (off == ADDR_W'(OFF_LCR))    sel = SEL_LCR;
            else if (off == ADDR_W'(OFF_STAT))   sel = SEL_STAT;
        end
    end
endmodule

// File: rtl/uart_regblk_irq.sv
module uart_regblk_irq
    import uart_regblk_pkg::*;
(
    input  logic       rx_src,
    input  logic       thre_src,
    input  logic       busy_src,
    input  logic       fifo_on,
    output logic [7:0] iir,
    output logic       irq
);
    logic [3:0] code;

    always_comb begin
        if (rx_src)        code = IID_RXAV;
        else if (thre_src) code = IID_THRE;
        else if (busy_src) code = IID_BUSY;
        else               code = IID_NONE;
        iir = {fifo_on, fifo_on, 2'b00, code};
        irq = (code != IID_NONE);
    end
endmodule

// File: rtl/uart_regblk_stat.sv
module uart_regblk_stat #(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             busy,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic [7:0]       usr
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

    always_comb begin
        usr    = '0;
        usr[0] = busy;
        usr[1] = (tx_level != FULL);
        usr[2] = (tx_level == '0);
        usr[3] = (rx_level != '0);
        usr[4] = (rx_level == FULL);
    end
endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter  int ADDR_W     = 8,
    parameter  int REG_SHIFT  = 2,
    parameter  int FIFO_DEPTH = 16,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              eng_busy,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [7:0]        rx_head,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    output logic              rx_pop,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic              fifo_on,
    output logic [7:0]        line_ctrl,
    output logic [15:0]       divisor,
    output logic              irq
);
    localparam logic [LVL_W-1:0] TX_FULL = LVL_W'(FIFO_DEPTH);

    regs_t      st_d, st_q;
    reg_sel_e   sel;
    logic [7:0] iir_val;
    logic [7:0] usr_val;
    logic       wr_acc, rd_acc;

    uart_regblk_decode #(
        .ADDR_W   (ADDR_W),
        .REG_SHIFT(REG_SHIFT)
    ) decode_i (
        .addr(req_addr),
        .dlab(st_q.lcr[7]),
        .sel (sel)
    );

    uart_regblk_irq irq_i (
        .rx_src  (st_q.ier[0] && (rx_level != '0)),
        .thre_src(st_q.ier[1] && (tx_level == '0)),
        .busy_src(st_q.busy_pend),
        .fifo_on (st_q.fifo_on),
        .iir     (iir_val),
        .irq     (irq)
    );

    uart_regblk_stat #(
        .FIFO_DEPTH(FIFO_DEPTH),
        .LVL_W     (LVL_W)
    ) stat_i (
        .busy    (eng_busy),
        .tx_level(tx_level),
        .rx_level(rx_level),
        .usr     (usr_val)
    );

    always_comb begin
        st_d          = st_q;
        st_d.tx_push  = 1'b0;
        st_d.rx_pop   = 1'b0;
        st_d.tx_flush = 1'b0;
        st_d.rx_flush = 1'b0;
        st_d.rd_valid = 1'b0;
        wr_acc        = req_valid && req_write;
        rd_acc        = req_valid && !req_write;

        if (wr_acc) begin
            case (sel)
                SEL_RXTX: begin
                    if (tx_level != TX_FULL) begin
                        st_d.tx_push = 1'b1;
                        st_d.tx_byte = req_wdata;
                    end
                end
                SEL_IER:  st_d.ier = req_wdata[3:0];
                SEL_DLL:  st_d.dll = req_wdata;
                SEL_DLH:  st_d.dlh = req_wdata;
                SEL_IIRFCR: begin
                    st_d.fifo_on  = req_wdata[0];
                    st_d.rx_flush = req_wdata[1];
                    st_d.tx_flush = req_wdata[2];
                end
                SEL_LCR: begin
                    // Guard: line control frozen while the engine is busy
                    if (eng_busy) st_d.busy_pend = 1'b1;
                    else          st_d.lcr       = req_wdata;
                end
                default: ;
            endcase
        end

        if (rd_acc) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_data  = 8'h00;
            case (sel)
                SEL_RXTX: begin
                    st_d.rd_data = rx_head;
                    st_d.rx_pop  = (rx_level != '0);
                end
                SEL_IER:    st_d.rd_data = {4'h0, st_q.ier};
                SEL_DLL:    st_d.rd_data = st_q.dll;
                SEL_DLH:    st_d.rd_data = st_q.dlh;
                SEL_IIRFCR: st_d.rd_data = iir_val;
                SEL_LCR:    st_d.rd_data = st_q.lcr;
                SEL_STAT: begin
                    st_d.rd_data   = usr_val;
                    st_d.busy_pend = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rd_data;
    assign rd_valid  = st_q.rd_valid;
    assign tx_push   = st_q.tx_push;
    assign tx_byte   = st_q.tx_byte;
    assign rx_pop    = st_q.rx_pop;
    assign tx_flush  = st_q.tx_flush;
    assign rx_flush  = st_q.rx_flush;
    assign fifo_on   = st_q.fifo_on;
    assign line_ctrl = st_q.lcr;
    assign divisor   = {st_q.dlh, st_q.dll};
endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk #(
    parameter  int ADDR_W     = 8,
    parameter  int REG_SHIFT  = 2,
    parameter  int FIFO_DEPTH = 16,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_wdata,
    input logic              rd_valid,
    input logic              eng_busy,
    input logic [LVL_W-1:0]  tx_level,
    input logic              tx_push,
    input logic              tx_flush,
    input logic              rx_flush,
    input logic [7:0]        line_ctrl,
    input logic [15:0]       divisor,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0 << REG_SHIFT);
    localparam logic [ADDR_W-1:0] A_FCR  = ADDR_W'(2 << REG_SHIFT);
    localparam logic [ADDR_W-1:0] A_LCR  = ADDR_W'(3 << REG_SHIFT);

    logic lcr_blocked, data_wr;
    assign lcr_blocked = req_valid && req_write && (req_addr == A_LCR) && eng_busy;
    assign data_wr     = req_valid && req_write && (req_addr == A_DATA) && !line_ctrl[7];

    a_r4_lcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_blocked |=> $stable(line_ctrl));

    a_r5_busy_irq: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_blocked |=> irq);

    a_r3_push_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(data_wr));

    a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_level == LVL_W'(FIFO_DEPTH)) |=> !tx_push);

    a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush || rx_flush) |-> $past(req_valid && req_write && req_addr == A_FCR));

    a_r11_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    a_r2_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(divisor));
endmodule

bind uart_regblk uart_regblk_chk #(
    .ADDR_W    (ADDR_W),
    .REG_SHIFT (REG_SHIFT),
    .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_valid (rd_valid),
    .eng_busy (eng_busy),
    .tx_level (tx_level),
    .tx_push  (tx_push),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .line_ctrl(line_ctrl),
    .divisor  (divisor),
    .irq      (irq)
);

// File: tb/uart_regblk_tb_top.sv
`timescale 1ns/100ps
module uart_regblk_tb_top;
    localparam int AW = 8;
    localparam int RS = 2;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);
    localparam int NVEC = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          eng_busy = 1'b0;
    logic [LW-1:0] tx_level = '0, rx_level = '0;
    logic [7:0]    rx_head = 8'h5A;
    logic          tx_push, rx_pop, tx_flush, rx_flush, fifo_on, irq;
    logic [7:0]    tx_byte, line_ctrl;
    logic [15:0]   divisor;

    int checks = 0, bad = 0, cyc = 0;
    logic done = 1'b0;

    logic [7:0] c_rd;
    logic       c_valid, c_push, c_pop, c_txf, c_rxf;
    logic [7:0] c_byte;

    always #2.5 clk = ~clk;

    uart_regblk #(.ADDR_W(AW), .REG_SHIFT(RS), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .eng_busy(eng_busy), .tx_level(tx_level), .rx_level(rx_level), .rx_head(rx_head),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .tx_flush(tx_flush),
        .rx_flush(rx_flush), .fifo_on(fifo_on), .line_ctrl(line_ctrl), .divisor(divisor),
        .irq(irq)
    );

    // Vector: {req(4), write(1), busy(1), offset(5), wdata(8), expected read(8)}
    localparam logic [26:0] VEC [NVEC] = '{
        {4'd6, 1'b0, 1'b0, 5'h1F, 8'h00, 8'h06},  // R6 idle status
        {4'd6, 1'b0, 1'b1, 5'h1F, 8'h00, 8'h07},  // R6 busy bit
        {4'd2, 1'b1, 1'b0, 5'h03, 8'h83, 8'h00},  // R2 set divisor access
        {4'd2, 1'b0, 1'b0, 5'h03, 8'h00, 8'h83},  // R2
        {4'd2, 1'b1, 1'b0, 5'h00, 8'h34, 8'h00},  // R2 divisor low
        {4'd2, 1'b1, 1'b0, 5'h01, 8'h12, 8'h00},  // R2 divisor high
        {4'd2, 1'b0, 1'b0, 5'h00, 8'h00, 8'h34},  // R2
        {4'd2, 1'b0, 1'b0, 5'h01, 8'h00, 8'h12},  // R2
        {4'd4, 1'b1, 1'b1, 5'h03, 8'h03, 8'h00},  // R4 dropped write
        {4'd4, 1'b0, 1'b0, 5'h03, 8'h00, 8'h83},  // R4 unchanged
        {4'd5, 1'b0, 1'b0, 5'h02, 8'h00, 8'h07},  // R5 busy-detect code
        {4'd5, 1'b0, 1'b0, 5'h02, 8'h00, 8'h07},  // R5 IIR read keeps it
        {4'd5, 1'b0, 1'b0, 5'h1F, 8'h00, 8'h06},  // R5 status read clears
        {4'd5, 1'b0, 1'b0, 5'h02, 8'h00, 8'h01},  // R5 cleared
        {4'd4, 1'b1, 1'b0, 5'h03, 8'h03, 8'h00},  // R4 accepted write
        {4'd4, 1'b0, 1'b0, 5'h03, 8'h00, 8'h03},  // R4
        {4'd3, 1'b0, 1'b0, 5'h00, 8'h00, 8'h5A},  // R3 data read
        {4'd3, 1'b1, 1'b0, 5'h01, 8'hF3, 8'h00},  // R3 IER write
        {4'd3, 1'b0, 1'b0, 5'h01, 8'h00, 8'h03},  // R3 IER keeps low nibble
        {4'd8, 1'b0, 1'b0, 5'h02, 8'h00, 8'h02},  // R8 tx empty source
        {4'd7, 1'b1, 1'b0, 5'h02, 8'h01, 8'h00},  // R7 FIFO enable
        {4'd7, 1'b0, 1'b0, 5'h02, 8'h00, 8'hC2},  // R7 IIR top bits
        {4'd2, 1'b1, 1'b0, 5'h03, 8'h80, 8'h00},  // R2
        {4'd2, 1'b0, 1'b0, 5'h01, 8'h00, 8'h12},  // R2
        {4'd2, 1'b1, 1'b0, 5'h03, 8'h03, 8'h00}   // R2
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [7:0] a, input logic [7:0] wd, input logic b);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd; eng_busy = b;
        @(posedge clk);
        #1;
        c_rd = rd_data; c_valid = rd_valid; c_push = tx_push; c_byte = tx_byte;
        c_pop = rx_pop; c_txf = tx_flush; c_rxf = rx_flush;
        req_valid = 1'b0; req_write = 1'b0; eng_busy = 1'b0;
    endtask

    function automatic logic [7:0] ad(input int off);
        return 8'(off << RS);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 line_ctrl", 16'(line_ctrl), 16'h0);
        check("R1 divisor", divisor, 16'h0);
        check("R1 irq/fifo_on/strobes", 16'({irq, fifo_on, tx_push, rx_pop, tx_flush, rx_flush}), 16'h0);
        acc(1'b0, ad(2), 8'h00, 1'b0);
        check("R1 IIR", 16'(c_rd), 16'h01);
        check("R11 rd_valid", 16'(c_valid), 16'h1);

        for (int i = 0; i < NVEC; i++) begin
            logic [26:0] v;
            v = VEC[i];
            acc(v[22], ad(int'(v[20:16])), v[15:8], v[21]);
            if (!v[22]) check($sformatf("R%0d vector %0d", v[26:23], i), 16'(c_rd), 16'(v[7:0]));
            if (v[22] && v[20:16] == 5'h00) check("R2 no push with divisor access", 16'(c_push), 16'h0);
        end
        check("R2 divisor output", divisor, 16'h1234);

        // R9 misaligned addresses select nothing
        acc(1'b0, ad(3) | 8'h01, 8'h00, 1'b0);
        check("R9 misaligned read", 16'(c_rd), 16'h0);
        acc(1'b1, ad(3) | 8'h01, 8'hFF, 1'b0);
        check("R9 misaligned write", 16'(line_ctrl), 16'h03);
        acc(1'b0, ad(5), 8'h00, 1'b0);
        check("R11 unmapped read", 16'(c_rd), 16'h0);

        // R3 transmit push
        acc(1'b1, ad(0), 8'hA5, 1'b0);
        check("R3 tx_push", 16'({c_push, c_byte}), 16'h1A5);
        @(posedge clk); #1;
        check("R3 push one cycle", 16'(tx_push), 16'h0);

        // R10 full transmit FIFO
        tx_level = LW'(DEPTH);
        acc(1'b1, ad(0), 8'h11, 1'b0);
        check("R10 no push when full", 16'(c_push), 16'h0);
        acc(1'b0, ad(31), 8'h00, 1'b0);
        check("R6 status tx full", 16'(c_rd), 16'h00);
        tx_level = '0;

        // R3 / R10 receive pop
        rx_level = LW'(3);
        acc(1'b0, ad(0), 8'h00, 1'b0);
        check("R3 rx_pop", 16'({c_pop, c_rd}), 16'h15A);
        rx_level = '0;
        acc(1'b0, ad(0), 8'h00, 1'b0);
        check("R10 no pop when empty", 16'(c_pop), 16'h0);
        rx_level = LW'(DEPTH);
        acc(1'b0, ad(31), 8'h00, 1'b0);
        check("R6 status rx full", 16'(c_rd), 16'h1E);

        // R8 priority ordering
        rx_level = LW'(1);
        acc(1'b1, ad(3), 8'h07, 1'b1);
        check("R4 guarded lcr", 16'(line_ctrl), 16'h03);
        acc(1'b0, ad(2), 8'h00, 1'b0);
        check("R8 rx data wins", 16'({irq, c_rd}), 16'h1C4);
        rx_level = '0;
        acc(1'b0, ad(2), 8'h00, 1'b0);
        check("R8 tx empty next", 16'(c_rd), 16'hC2);
        acc(1'b1, ad(1), 8'h00, 1'b0);
        acc(1'b0, ad(2), 8'h00, 1'b0);
        check("R8 busy-detect last", 16'({irq, c_rd}), 16'h1C7);
        acc(1'b0, ad(31), 8'h00, 1'b0);
        #1;
        check("R5 irq cleared", 16'(irq), 16'h0);
        acc(1'b0, ad(2), 8'h00, 1'b0);
        check("R8 none", 16'(c_rd), 16'hC1);

        // R7 flush pulses
        acc(1'b1, ad(2), 8'h07, 1'b0);
        check("R7 flush pulses", 16'({c_txf, c_rxf}), 16'h3);
        @(posedge clk); #1;
        check("R7 pulses one cycle", 16'({tx_flush, rx_flush}), 16'h0);
        check("R7 fifo enabled", 16'(fifo_on), 16'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule